// File: doc/BRIEF.md
# Channel Command List Sequencer

This block is the data-channel engine of a mass-storage controller. A start pulse makes it fetch the first command word from its own four-word slot in a fixed channel table. From there it walks a chain of 36-bit command words held in memory. A command either ends the list (halt), redirects the list pointer (jump), or moves a counted run of data words between memory and a device-side word FIFO (transfer). For each transfer the block keeps a 22-bit memory address and an 11-bit word count. The address steps up, or steps down when the reverse modifier is set.

When the list ends, whether normally, through an error or through a stop request, the block writes two words back to its slot. The first is a status word: a fixed always-one bit, a bit that is set when there was no address parity fault, the error flags, and the address of the last fetched command plus one. The second is the current command word, updated with the residual count and the next address. A single-cycle `done` pulse follows. The fourth word of the slot is left to software and is never written. Memory accesses use a request/acknowledge port that holds the request until the acknowledge. The port also returns a nonexistent-memory indication and a parity indication.

Top module: `ccl_sequencer`

## Requirements
- R1: After reset, and whenever `busy` is low, the block issues no memory request, does not pop the device source and does not offer words to the device sink.
- R2: A `start` pulse while idle clears all flags and fetches the first command from the slot base `TABLE_BASE + 4*CHAN_IDX`. A command whose bits [35:33] are 000 or 001 (halt) ends the list.
- R3: A command whose bits [35:34] are 01 (jump) loads the list pointer from bits [21:0]. The next command is fetched from that address, and no data moves.
- R4: A command with bit [35] set is a transfer. Bits [32:22] hold the word count and bits [21:0] the starting address. With `dev_dir` low, each word taken from the device source is written to memory at successive ascending addresses.
- R5: With bit [33] of a transfer set (reverse), the address decrements after each word.
- R6: With bit [34] of a transfer set, the list ends once the count reaches zero. With bit [34] clear, the next command is fetched and processing continues.
- R7: With `dev_dir` high, memory words are read in address order and presented on `dev_wvalid`/`dev_wdata`. Each word is held until `dev_wready`.
- R8: At the end of the list, the status word is written to slot+1 and then the command word `{op[2:0], residual count, next address}` to slot+2, followed by a one-cycle `done`. Status layout: [35]=1, [34]=fetch parity, [33]=1, [32]=count not zero, [31]=nonexistent memory, [26]=device transfer error, [25]=not-ready start, [24]=long count, [23]=short count, [22]=overrun, [21:0]=last command address plus one. All other bits are 0. Slot+3 is never written.
- R9: If `dev_done` is asserted while words remain, the list ends with the short-count flag set.
- R10: If the count of a halt-after transfer reaches zero while the device source still offers a word (device-to-memory), the long-count flag is set. That word is not taken.
- R11: A nonexistent-memory acknowledge on any access sets bit [31] and ends the list. On a data write, the count and address stay at the failing word.
- R12: A parity indication on a command fetch sets bit [34] and ends the list without executing the word.
- R13: During a transfer, `stop` ends the list with no flag. `dev_err` ends it with bit [26] set, and `dev_ovr` ends it with bit [22] set.
- R14: A `start` while busy does not restart the list. It sets bit [25] in the stored status.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin walking the command list |
| stop | input | 1 | End the current transfer and store status |
| dev_dir | input | 1 | Sampled at start: 0 device-to-memory, 1 memory-to-device |
| busy | output | 1 | Sequencer not idle |
| done | output | 1 | One-cycle pulse after the write-back |
| mem_req | output | 1 | Memory request, held until acknowledge |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | 22 | Word address |
| mem_wdata | output | 36 | Write data |
| mem_ack | input | 1 | Request completed |
| mem_rdata | input | 36 | Read data, valid with acknowledge |
| mem_nxm | input | 1 | Address does not exist, valid with acknowledge |
| mem_par_err | input | 1 | Read data parity fault, valid with acknowledge |
| dev_rvalid | input | 1 | Device source has a word |
| dev_rdata | input | 36 | Device source word |
| dev_rready | output | 1 | Pop the device source word |
| dev_wvalid | output | 1 | Word offered to the device sink |
| dev_wdata | output | 36 | Word to the device sink |
| dev_wready | input | 1 | Device sink accepts the word |
| dev_done | input | 1 | Device has ended the transfer |
| dev_err | input | 1 | Device transfer error |
| dev_ovr | input | 1 | Device overrun |

## Verification
The bench targets the end-of-transfer corners. One case ends the device data early, so a design that failed to flag it would report a clean status with a nonzero residual count. Another leaves one word pending when the count expires, so a design that wrongly kept draining would write past the buffer and leave the long-count flag clear. Reverse runs and chained transfers catch an address unit that always increments, or that halts after every command. Fetch parity and nonexistent-memory cases check that a faulting word is neither executed nor counted. A second start while busy must set the not-ready bit and leave the residual count untouched.

// File: rtl/ccl_pkg.sv
// Shared types for the channel command list sequencer.
// Assumes a single channel slot and a single outstanding memory request.
package ccl_pkg;

    typedef enum logic [3:0] {
        S_IDLE,
        S_FETCH,
        S_EXEC,
        S_XFER,
        S_XWR,
        S_XRD,
        S_XPUSH,
        S_STORE_ST,
        S_STORE_CW
    } seq_state_t;

    typedef struct packed {
        logic mpar;
        logic nxm;
        logic lxfe;
        logic notrdy;
        logic longc;
        logic shortc;
        logic ovn;
    } flags_t;

endpackage

// File: rtl/ccl_cmd_decode.sv
// Splits a command word into opcode class, modifiers, count and address.
// Assumes the opcode is the top three bits, the count sits above the address.
module ccl_cmd_decode #(
    parameter int ADDR_W = 22,
    parameter int CNT_W  = 11
) (
    input  logic [ADDR_W+CNT_W+2:0] word,
    output logic                    is_xfer,
    output logic                    is_jump,
    output logic                    halt_after,
    output logic                    reverse,
    output logic [CNT_W-1:0]        count,
    output logic [ADDR_W-1:0]       addr
);
    localparam int WORD_W = ADDR_W + CNT_W + 3;

    logic [2:0] op;

    // Pure field extraction and opcode classification.
    always_comb begin
        op         = word[WORD_W-1 -: 3];
        is_xfer    = op[2];
        is_jump    = (op[2:1] == 2'b01);
        halt_after = op[1];
        reverse    = op[0];
        count      = word[ADDR_W +: CNT_W];
        addr       = word[ADDR_W-1:0];
    end
endmodule

// File: rtl/ccl_addr_count.sv
// Holds the running data address and remaining word count of a transfer.
// Assumes load and step are never asserted together.
module ccl_addr_count #(
    parameter int ADDR_W = 22,
    parameter int CNT_W  = 11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [ADDR_W-1:0] ld_addr,
    input  logic [CNT_W-1:0]  ld_cnt,
    input  logic              ld_rev,
    input  logic              step,
    output logic [ADDR_W-1:0] cur_addr,
    output logic [CNT_W-1:0]  cur_cnt,
    output logic              cnt_zero
);
    logic rev_q;

    // Load from a new command, or advance one word in the chosen direction.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_addr <= '0;
            cur_cnt  <= '0;
            rev_q    <= 1'b0;
        end else if (load) begin
            cur_addr <= ld_addr;
            cur_cnt  <= ld_cnt;
            rev_q    <= ld_rev;
        end else if (step) begin
            cur_addr <= rev_q ? cur_addr - 1'b1 : cur_addr + 1'b1;
            cur_cnt  <= cur_cnt - 1'b1;
        end
    end

    // Count exhaustion flag for the sequencer.
    always_comb cnt_zero = (cur_cnt == '0);
endmodule

// File: rtl/ccl_status_pack.sv
// Assembles the fixed-format status word from flags and the list pointer.
// Assumes the word is wide enough that flag bits sit above the pointer field.
module ccl_status_pack
    import ccl_pkg::*;
#(
    parameter int ADDR_W = 22,
    parameter int CNT_W  = 11
) (
    input  flags_t                  flags,
    input  logic                    cnt_nz,
    input  logic [ADDR_W-1:0]       ptr,
    output logic [ADDR_W+CNT_W+2:0] word
);
    localparam int W = ADDR_W + CNT_W + 3;

    // Place each flag at its fixed position counted from the top bit.
    always_comb begin
        word                = '0;
        word[W-1]           = 1'b1;
        word[W-2]           = flags.mpar;
        word[W-3]           = 1'b1;
        word[W-4]           = cnt_nz;
        word[W-5]           = flags.nxm;
        word[W-10]          = flags.lxfe;
        word[W-11]          = flags.notrdy;
        word[W-12]          = flags.longc;
        word[W-13]          = flags.shortc;
        word[W-14]          = flags.ovn;
        word[ADDR_W-1:0]    = ptr;
    end
endmodule

// File: rtl/ccl_sequencer.sv
// Channel command list sequencer: walks halt/jump/transfer commands,
// moves words between memory and a device FIFO, writes status back.
// Assumes memory holds mem_rdata/mem_nxm/mem_par_err valid only with mem_ack,
// and that dev_dir is stable while busy.
module ccl_sequencer
    import ccl_pkg::*;
#(
    parameter int ADDR_W     = 22,
    parameter int CNT_W      = 11,
    parameter int TABLE_BASE = 0,
    parameter int CHAN_IDX   = 1
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    start,
    input  logic                    stop,
    input  logic                    dev_dir,
    output logic                    busy,
    output logic                    done,
    output logic                    mem_req,
    output logic                    mem_we,
    output logic [ADDR_W-1:0]       mem_addr,
    output logic [ADDR_W+CNT_W+2:0] mem_wdata,
    input  logic                    mem_ack,
    input  logic [ADDR_W+CNT_W+2:0] mem_rdata,
    input  logic                    mem_nxm,
    input  logic                    mem_par_err,
    input  logic                    dev_rvalid,
    input  logic [ADDR_W+CNT_W+2:0] dev_rdata,
    output logic                    dev_rready,
    output logic                    dev_wvalid,
    output logic [ADDR_W+CNT_W+2:0] dev_wdata,
    input  logic                    dev_wready,
    input  logic                    dev_done,
    input  logic                    dev_err,
    input  logic                    dev_ovr
);
    localparam int WORD_W = ADDR_W + CNT_W + 3;
    localparam logic [ADDR_W-1:0] AREA_BASE = ADDR_W'(TABLE_BASE + 4 * CHAN_IDX);
    localparam logic [ADDR_W-1:0] ST_ADDR   = AREA_BASE + ADDR_W'(1);
    localparam logic [ADDR_W-1:0] CW_ADDR   = AREA_BASE + ADDR_W'(2);

    seq_state_t          state;
    logic [ADDR_W-1:0]   ptr;
    flags_t              flags;
    logic [WORD_W-1:0]   ccw_q;
    logic [WORD_W-1:0]   dbuf;
    logic                dir_q;

    logic                d_xfer, d_jump, d_halt_after, d_rev;
    logic [CNT_W-1:0]    d_cnt;
    logic [ADDR_W-1:0]   d_addr;
    logic [ADDR_W-1:0]   cur_addr;
    logic [CNT_W-1:0]    cur_cnt;
    logic                cnt_zero;
    logic                ac_load, ac_step;
    logic                xfer_abort, take_word;
    logic [WORD_W-1:0]   stat_word, ccw_out;

    ccl_cmd_decode #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_decode (
        .word       (ccw_q),
        .is_xfer    (d_xfer),
        .is_jump    (d_jump),
        .halt_after (d_halt_after),
        .reverse    (d_rev),
        .count      (d_cnt),
        .addr       (d_addr)
    );

    ccl_addr_count #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_addr_count (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (ac_load),
        .ld_addr  (d_addr),
        .ld_cnt   (d_cnt),
        .ld_rev   (d_rev),
        .step     (ac_step),
        .cur_addr (cur_addr),
        .cur_cnt  (cur_cnt),
        .cnt_zero (cnt_zero)
    );

    ccl_status_pack #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_status (
        .flags  (flags),
        .cnt_nz (!cnt_zero),
        .ptr    (ptr),
        .word   (stat_word)
    );

    // Control strobes for the address/count unit and the device source.
    always_comb begin
        ac_load    = (state == S_EXEC);
        ac_step    = (state == S_XWR && mem_ack && !mem_nxm) ||
                     (state == S_XPUSH && dev_wready);
        xfer_abort = stop || dev_err || dev_ovr;
        take_word  = (state == S_XFER) && !xfer_abort && !cnt_zero &&
                     !dev_done && !dir_q && dev_rvalid;
        ccw_out    = {ccw_q[WORD_W-1 -: 3], cur_cnt, cur_addr};
    end

    // Memory port and device sink drive, decoded from the state.
    always_comb begin
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = ptr;
        mem_wdata = '0;
        case (state)
            S_FETCH:    mem_req = 1'b1;
            S_XWR:      begin mem_req = 1'b1; mem_we = 1'b1; mem_addr = cur_addr; mem_wdata = dbuf; end
            S_XRD:      begin mem_req = 1'b1; mem_addr = cur_addr; end
            S_STORE_ST: begin mem_req = 1'b1; mem_we = 1'b1; mem_addr = ST_ADDR; mem_wdata = stat_word; end
            S_STORE_CW: begin mem_req = 1'b1; mem_we = 1'b1; mem_addr = CW_ADDR; mem_wdata = ccw_out; end
            default:    ;
        endcase
        busy       = (state != S_IDLE);
        dev_rready = take_word;
        dev_wvalid = (state == S_XPUSH);
        dev_wdata  = dbuf;
    end

    // Sequencer state, list pointer, flags and data buffer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= S_IDLE;
            ptr   <= '0;
            flags <= '0;
            ccw_q <= '0;
            dbuf  <= '0;
            dir_q <= 1'b0;
            done  <= 1'b0;
        end else begin
            done <= 1'b0;
            case (state)
                S_IDLE: if (start) begin
                    ptr   <= AREA_BASE;
                    flags <= '0;
                    dir_q <= dev_dir;
                    state <= S_FETCH;
                end
                S_FETCH: if (mem_ack) begin
                    ptr <= ptr + 1'b1;
                    if (mem_nxm) begin
                        flags.nxm <= 1'b1;
                        state     <= S_STORE_ST;
                    end else if (mem_par_err) begin
                        flags.mpar <= 1'b1;
                        state      <= S_STORE_ST;
                    end else begin
                        ccw_q <= mem_rdata;
                        state <= S_EXEC;
                    end
                end
                S_EXEC: begin
                    if (d_xfer)      state <= S_XFER;
                    else if (d_jump) begin
                        ptr   <= d_addr;
                        state <= S_FETCH;
                    end else         state <= S_STORE_ST;
                end
                S_XFER: begin
                    if (stop)         state <= S_STORE_ST;
                    else if (dev_err) begin flags.lxfe <= 1'b1; state <= S_STORE_ST; end
                    else if (dev_ovr) begin flags.ovn  <= 1'b1; state <= S_STORE_ST; end
                    else if (cnt_zero) begin
                        if (d_halt_after) begin
                            if (!dir_q && dev_rvalid) flags.longc <= 1'b1;
                            state <= S_STORE_ST;
                        end else state <= S_FETCH;
                    end
                    else if (dev_done) begin flags.shortc <= 1'b1; state <= S_STORE_ST; end
                    else if (dir_q)    state <= S_XRD;
                    else if (dev_rvalid) begin
                        dbuf  <= dev_rdata;
                        state <= S_XWR;
                    end
                end
                S_XWR: if (mem_ack) begin
                    if (mem_nxm) begin flags.nxm <= 1'b1; state <= S_STORE_ST; end
                    else state <= S_XFER;
                end
                S_XRD: if (mem_ack) begin
                    if (mem_nxm) begin flags.nxm <= 1'b1; state <= S_STORE_ST; end
                    else begin dbuf <= mem_rdata; state <= S_XPUSH; end
                end
                S_XPUSH:    if (dev_wready) state <= S_XFER;
                S_STORE_ST: if (mem_ack) state <= S_STORE_CW;
                S_STORE_CW: if (mem_ack) begin
                    state <= S_IDLE;
                    done  <= 1'b1;
                end
                default: state <= S_IDLE;
            endcase
            if (start && state != S_IDLE) flags.notrdy <= 1'b1;
        end
    end
endmodule

// File: rtl/ccl_sequencer_checker.sv
// Temporal checks on the sequencer ports, bound into every instance.
// Assumes the memory model keeps ack to a single cycle per request.
module ccl_sequencer_checker #(
    parameter int ADDR_W = 22,
    parameter int WORD_W = 36,
    parameter logic [ADDR_W-1:0] AREA = '0
) (
    input logic              clk,
    input logic              rst_n,
    input logic              busy,
    input logic              done,
    input logic              mem_req,
    input logic              mem_we,
    input logic              mem_ack,
    input logic [ADDR_W-1:0] mem_addr,
    input logic [WORD_W-1:0] mem_wdata,
    input logic              dev_rready,
    input logic              dev_wvalid,
    input logic              dev_wready,
    input logic [WORD_W-1:0] dev_wdata
);
    localparam logic [ADDR_W-1:0] CW_A    = AREA + ADDR_W'(2);
    localparam logic [ADDR_W-1:0] SPARE_A = AREA + ADDR_W'(3);

    a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!mem_req && !dev_rready && !dev_wvalid));

    a_r4_req_held: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata)));

    a_r7_push_held: assert property (@(posedge clk) disable iff (!rst_n)
        (dev_wvalid && !dev_wready) |=> (dev_wvalid && $stable(dev_wdata)));

    a_r8_spare_untouched: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we) |-> (mem_addr != SPARE_A));

    a_r8_done_after_store: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(mem_ack && mem_we && mem_addr == CW_A));

    a_r2_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);
endmodule

bind ccl_sequencer ccl_sequencer_checker #(
    .ADDR_W (ADDR_W),
    .WORD_W (WORD_W),
    .AREA   (AREA_BASE)
) u_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .busy       (busy),
    .done       (done),
    .mem_req    (mem_req),
    .mem_we     (mem_we),
    .mem_ack    (mem_ack),
    .mem_addr   (mem_addr),
    .mem_wdata  (mem_wdata),
    .dev_rready (dev_rready),
    .dev_wvalid (dev_wvalid),
    .dev_wready (dev_wready),
    .dev_wdata  (dev_wdata)
);

// File: tb/ccl_sequencer_bench.sv
module ccl_sequencer_bench;
    localparam int AREA = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #4 clk = ~clk;

    logic        start = 1'b0, stop = 1'b0, dev_dir = 1'b0;
    logic        busy, done, mem_req, mem_we, dev_rready, dev_wvalid;
    logic [21:0] mem_addr;
    logic [35:0] mem_wdata, dev_wdata;
    logic        mem_ack = 1'b0, mem_nxm = 1'b0, mem_par_err = 1'b0;
    logic [35:0] mem_rdata = '0;
    logic        dev_rvalid, dev_done;
    logic [35:0] dev_rdata;
    logic        dev_wready = 1'b0, dev_err = 1'b0, dev_ovr = 1'b0;

    ccl_sequencer u_ccl_sequencer (
        .clk(clk), .rst_n(rst_n), .start(start), .stop(stop), .dev_dir(dev_dir),
        .busy(busy), .done(done), .mem_req(mem_req), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_ack(mem_ack),
        .mem_rdata(mem_rdata), .mem_nxm(mem_nxm), .mem_par_err(mem_par_err),
        .dev_rvalid(dev_rvalid), .dev_rdata(dev_rdata), .dev_rready(dev_rready),
        .dev_wvalid(dev_wvalid), .dev_wdata(dev_wdata), .dev_wready(dev_wready),
        .dev_done(dev_done), .dev_err(dev_err), .dev_ovr(dev_ovr)
    );

    int checks = 0;
    int fails = 0;

    // Memory model: 4096 words, random 0..2 cycle acknowledge delay.
    logic [35:0] mem [0:4095];
    logic [21:0] par_addr = 22'h3FFFFF;
    int          wait_cnt = 0;
    always @(posedge clk) begin
        if (mem_ack) mem_ack <= 1'b0;
        else if (mem_req) begin
            if (wait_cnt == 0) begin
                mem_ack     <= 1'b1;
                mem_nxm     <= (mem_addr >= 22'd4096);
                mem_par_err <= !mem_we && (mem_addr == par_addr);
                mem_rdata   <= (mem_addr < 22'd4096) ? mem[mem_addr[11:0]] : 36'h0;
                if (mem_we && mem_addr < 22'd4096) mem[mem_addr[11:0]] = mem_wdata;
                wait_cnt    <= int'($urandom_range(2, 0));
            end else wait_cnt <= wait_cnt - 1;
        end
    end

    // Device model: ring source, capture sink, random sink readiness.
    logic [35:0] src [0:255];
    logic [35:0] sink [0:255];
    int unsigned src_idx = 0;
    int unsigned src_end = 0;
    int          sink_n = 0;
    logic        short_mode = 1'b0;
    assign dev_rvalid = (src_idx != src_end);
    assign dev_rdata  = src[src_idx[7:0]];
    assign dev_done   = short_mode && (src_idx == src_end);
    always @(posedge clk) begin
        if (dev_rvalid && dev_rready) src_idx <= src_idx + 1;
        if (dev_wvalid && dev_wready) begin
            sink[sink_n[7:0]] = dev_wdata;
            sink_n = sink_n + 1;
        end
        dev_wready <= ($urandom_range(3, 0) != 0);
    end

    task automatic check(input string tag, input logic [35:0] act, input logic [35:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [35:0] mk_cmd(input logic [2:0] op, input int cnt, input int adr);
        return {op, cnt[10:0], adr[21:0]};
    endfunction

    function automatic logic [35:0] exp_stat(input bit mpar, input bit cntnz, input bit nxm,
            input bit lxfe, input bit nr, input bit lw, input bit sw, input bit ovn, input int ptr);
        logic [35:0] w = '0;
        w[35] = 1'b1; w[34] = mpar; w[33] = 1'b1; w[32] = cntnz; w[31] = nxm;
        w[26] = lxfe; w[25] = nr; w[24] = lw; w[23] = sw; w[22] = ovn;
        w[21:0] = ptr[21:0];
        return w;
    endfunction

    task automatic load_src(input int n, output int base);
        base = int'(src_idx);
        for (int i = 0; i < n; i++) src[(base + i) % 256] = {4'($urandom), $urandom};
        src_end = src_idx + n;
    endtask

    task automatic pulse_start(input bit dir);
        @(negedge clk);
        dev_dir = dir;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic wait_done(input string tag);
        int n = 0;
        while (!done && n < 5000) begin
            @(negedge clk);
            n++;
        end
        check({tag, " completion"}, {35'h0, done}, 36'h1);
    endtask

    task automatic run_list(input bit dir, input string tag);
        pulse_start(dir);
        wait_done(tag);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=hung expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        int b;
        void'($urandom(32'd4242));
        for (int i = 0; i < 4096; i++) mem[i] = '0;
        mem[AREA+3] = 36'h5A5A5A5A5;
        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1 busy", {35'h0, busy}, 36'h0);
        check("R1 mem_req", {35'h0, mem_req}, 36'h0);
        check("R1 done", {35'h0, done}, 36'h0);
        check("R1 device side", {34'h0, dev_rready, dev_wvalid}, 36'h0);
        rst_n = 1'b1;
        @(negedge clk);

        // R2: halt as first command
        mem[AREA] = 36'h0;
        run_list(1'b0, "R2");
        check("R2 status", mem[AREA+1], exp_stat(0,0,0,0,0,0,0,0, AREA+1));
        check("R2 cmd word", mem[AREA+2], 36'h0);

        // R3 R4: jump to list, ascending device-to-memory transfer
        mem[AREA] = mk_cmd(3'b010, 0, 100);
        mem[100]  = mk_cmd(3'b110, 4, 200);
        load_src(4, b);
        run_list(1'b0, "R4");
        for (int k = 0; k < 4; k++) check("R4 data", mem[200+k], src[(b+k)%256]);
        check("R3 status ptr", mem[AREA+1], exp_stat(0,0,0,0,0,0,0,0, 101));
        check("R8 cmd word", mem[AREA+2], mk_cmd(3'b110, 0, 204));

        // R5: reverse transfer
        mem[100] = mk_cmd(3'b111, 3, 300);
        load_src(3, b);
        run_list(1'b0, "R5");
        for (int k = 0; k < 3; k++) check("R5 data", mem[300-k], src[(b+k)%256]);
        check("R5 cmd word", mem[AREA+2], mk_cmd(3'b111, 0, 297));

        // R6: chained transfers
        mem[AREA] = mk_cmd(3'b010, 0, 120);
        mem[120]  = mk_cmd(3'b100, 2, 400);
        mem[121]  = mk_cmd(3'b110, 3, 500);
        load_src(5, b);
        run_list(1'b0, "R6");
        check("R6 first", mem[401], src[(b+1)%256]);
        check("R6 second", mem[500], src[(b+2)%256]);
        check("R6 last", mem[502], src[(b+4)%256]);
        check("R6 status", mem[AREA+1], exp_stat(0,0,0,0,0,0,0,0, 122));
        mem[AREA] = mk_cmd(3'b010, 0, 100);

        // R7: memory-to-device
        mem[100] = mk_cmd(3'b110, 4, 700);
        for (int k = 0; k < 4; k++) mem[700+k] = {4'($urandom), $urandom};
        b = sink_n;
        load_src(0, b);
        b = sink_n;
        run_list(1'b1, "R7");
        check("R7 count", 36'(sink_n - b), 36'd4);
        for (int k = 0; k < 4; k++) check("R7 data", sink[(b+k)%256], mem[700+k]);

        // R9: short count
        mem[100] = mk_cmd(3'b110, 5, 800);
        load_src(2, b);
        short_mode = 1'b1;
        run_list(1'b0, "R9");
        short_mode = 1'b0;
        check("R9 status", mem[AREA+1], exp_stat(0,1,0,0,0,0,1,0, 101));
        check("R9 cmd word", mem[AREA+2], mk_cmd(3'b110, 3, 802));

        // R10: long count, extra word left unread
        mem[100] = mk_cmd(3'b110, 2, 850);
        mem[852] = 36'h123456789;
        load_src(3, b);
        run_list(1'b0, "R10");
        check("R10 status", mem[AREA+1], exp_stat(0,0,0,0,0,1,0,0, 101));
        check("R10 no extra write", mem[852], 36'h123456789);

        // R11: nonexistent memory on data write
        mem[100] = mk_cmd(3'b110, 2, 22'h3FFFF0);
        load_src(2, b);
        run_list(1'b0, "R11");
        check("R11 status", mem[AREA+1], exp_stat(0,1,1,0,0,0,0,0, 101));
        check("R11 cmd word", mem[AREA+2], mk_cmd(3'b110, 2, 22'h3FFFF0));

        // R12: parity fault on command fetch
        mem[AREA] = mk_cmd(3'b010, 0, 600);
        mem[600]  = mk_cmd(3'b110, 2, 900);
        par_addr  = 22'd600;
        load_src(2, b);
        run_list(1'b0, "R12");
        par_addr  = 22'h3FFFFF;
        check("R12 status", mem[AREA+1], exp_stat(1,0,0,0,0,0,0,0, 601));
        check("R12 not executed", 36'(src_idx - b), 36'd0);
        mem[AREA] = mk_cmd(3'b010, 0, 100);

        // R13: device error and overrun
        mem[100] = mk_cmd(3'b110, 2, 950);
        load_src(0, b);
        dev_err = 1'b1;
        run_list(1'b0, "R13");
        dev_err = 1'b0;
        check("R13 error status", mem[AREA+1], exp_stat(0,1,0,1,0,0,0,0, 101));
        dev_ovr = 1'b1;
        run_list(1'b0, "R13");
        dev_ovr = 1'b0;
        check("R13 overrun status", mem[AREA+1], exp_stat(0,1,0,0,0,0,0,1, 101));

        // R14 and R13 stop: second start while busy, then stop
        pulse_start(1'b0);
        repeat (12) @(negedge clk);
        check("R14 still busy", {35'h0, busy}, 36'h1);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (4) @(negedge clk);
        stop = 1'b1;
        @(negedge clk);
        stop = 1'b0;
        wait_done("R14");
        check("R14 status", mem[AREA+1], exp_stat(0,1,0,0,1,0,0,0, 101));
        check("R14 cmd word", mem[AREA+2], mk_cmd(3'b110, 2, 950));

        // Random single-command transfers, both directions and orders
        for (int it = 0; it < 40; it++) begin
            bit dir = 1'($urandom);
            bit rev = 1'($urandom);
            int n = int'($urandom_range(8, 1));
            int a = rev ? 2000 + it*16 + 8 : 2000 + it*16;
            int fin = rev ? a - n : a + n;
            mem[100] = mk_cmd({2'b11, rev}, n, a);
            if (dir) begin
                for (int k = 0; k < n; k++) mem[rev ? a-k : a+k] = {4'($urandom), $urandom};
                load_src(0, b);
                b = sink_n;
                run_list(1'b1, "R7 random");
                for (int k = 0; k < n; k++)
                    check(rev ? "R5 R7 random data" : "R7 random data", sink[(b+k)%256], mem[rev ? a-k : a+k]);
            end else begin
                load_src(n, b);
                run_list(1'b0, "R4 random");
                for (int k = 0; k < n; k++)
                    check(rev ? "R5 R4 random data" : "R4 random data", mem[rev ? a-k : a+k], src[(b+k)%256]);
            end
            check("R8 random status", mem[AREA+1], exp_stat(0,0,0,0,0,0,0,0, 101));
            check("R8 random cmd word", mem[AREA+2], mk_cmd({2'b11, rev}, 0, fin));
        end

        check("R8 spare word", mem[AREA+3], 36'h5A5A5A5A5);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule